// File: doc/BRIEF.md
# Critical Output Hold Wrapper

This block sits between a board power and reset controller and the pads that drive regulator enables and reset lines. Each of these critical outputs has its own hold register with a two-way select in front of it. The register either keeps its value or loads the matching controller output, and the pads are driven from these registers. After the logic has been reloaded without a power cycle, the controller starts up again from its initial state. While that happens, the wrapper keeps every pad at the value it had before, so that running supplies stay on and running processors are not reset. The controller then signals that it is ready, and from that clock edge on the pads follow it again.

A mode input marks the difference between a live reload and a cold power-up. On a cold power-up the controller drives the pads from the start and nothing is frozen. At reset the hold registers are loaded from a retained-state input vector, which stands for the pad levels kept across the reload. The vector value in the last reset cycle is the one the pads start from. A status output shows, on each cycle, whether the pad values came from a hold.

Top module: `crit_out_hold`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads `pad_o` with `retained_i` and clears `holding_o` to 0. After `rst_n` goes high, `retained_i` has no effect.
- R2: At a rising edge with `rst_n` high, `hitless_i` = 1 and `ctl_ready_i` = 0, `pad_o` keeps its value whatever `ctl_out_i` is.
- R3: At a rising edge with `rst_n` high and `hitless_i` = 0, `pad_o` takes the value of `ctl_out_i`, whatever `ctl_ready_i` is. A cold power-up is never frozen.
- R4: At a rising edge with `rst_n` high and `ctl_ready_i` = 1, `pad_o` takes the value of `ctl_out_i`. Handover happens on the first such edge, with one register of latency and no extra cycle.
- R5: Suppose `ctl_ready_i` falls back to 0 while `hitless_i` = 1. From the next edge on, `pad_o` stays at the values it had at that moment. It does not return to any default.
- R6: After each rising edge with `rst_n` high, `holding_o` is 1 if that edge held the pads (`hitless_i` = 1 and `ctl_ready_i` = 0), and 0 otherwise.
- R7: The pad width is the parameter `WIDTH` (default 8). Every bit has its own hold register, all bits share one select, and any bit pattern is kept exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the retained state |
| ctl_out_i | input | WIDTH | Outputs requested by the power/reset controller |
| ctl_ready_i | input | 1 | Controller reports normal operation |
| hitless_i | input | 1 | 1 = live reload, outputs held during init; 0 = cold power-up |
| retained_i | input | WIDTH | Pad levels kept across the reload |
| pad_o | output | WIDTH | Registered critical outputs to the pads |
| holding_o | output | 1 | 1 when the last edge held the pads |

## Verification
A wrong select shows up at the pads one cycle after the edge that uses it. Either a controller value leaks out during a hold, or a value stays frozen after handover. The mismatch appears at the first sampling point after that edge, and the bench compares the pads against its model on every cycle. A bad reset load shows in the first cycle after release, so every retained pattern is tried, and only in the hold mode does the pad keep that pattern. A stuck or inverted status flag is caught on the very next cycle, because the mode and ready inputs are toggled throughout the sweep.

// File: rtl/crit_out_hold.sv
module crit_out_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ctl_out_i,
  input  logic             ctl_ready_i,
  input  logic             hitless_i,
  input  logic [WIDTH-1:0] retained_i,
  output logic [WIDTH-1:0] pad_o,
  output logic             holding_o
);

  logic             freeze;
  logic [WIDTH-1:0] pad_q;
  logic             hold_q;

  assign freeze = hitless_i & ~ctl_ready_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        pad_q[b] <= retained_i[b];
      else if (!freeze)
        pad_q[b] <= ctl_out_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= freeze;
  end

  assign pad_o     = pad_q;
  assign holding_o = hold_q;

  p_reset_load_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_o == $past(retained_i)) && !holding_o);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hitless_i && !ctl_ready_i) |=> $stable(pad_o));

  p_cold_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hitless_i |=> pad_o == $past(ctl_out_i));

  p_ready_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ready_i |=> pad_o == $past(ctl_out_i));

  p_refreeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hitless_i && $fell(ctl_ready_i)) |=> $stable(pad_o));

  p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> holding_o == $past(hitless_i && !ctl_ready_i));

endmodule

// File: tb/crit_out_hold_tb.sv
module crit_out_hold_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ctl_out = '0;
  logic         ready = 1'b0;
  logic         hitless = 1'b0;
  logic [W-1:0] retained = '0;
  logic [W-1:0] pad;
  logic         holding;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_pad;
  logic         exp_hold;
  logic         prev_ready;

  always #4 clk = ~clk;

  crit_out_hold #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_out_i(ctl_out), .ctl_ready_i(ready),
    .hitless_i(hitless), .retained_i(retained), .pad_o(pad), .holding_o(holding)
  );

  task automatic chk_pad(string req);
    checks++;
    if (pad !== exp_pad) begin
      errors++;
      $display("FAIL %s pad actual %b expected %b", req, pad, exp_pad);
    end
  endtask

  task automatic chk_hold(string req);
    checks++;
    if (holding !== exp_hold) begin
      errors++;
      $display("FAIL %s holding actual %b expected %b", req, holding, exp_hold);
    end
  endtask

  task automatic step(logic h, logic r, logic [W-1:0] c, logic [W-1:0] junk_ret);
    string req;
    hitless = h; ready = r; ctl_out = c; retained = junk_ret;
    @(posedge clk);
    if (!h || r) exp_pad = c;
    exp_hold = h && !r;
    @(negedge clk);
    if (h && !r && prev_ready) req = "R5";
    else if (h && !r)          req = "R2";
    else if (!h)               req = "R3";
    else                       req = "R4";
    chk_pad(req);
    chk_hold("R6");
    prev_ready = r;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int ret = 0; ret < (1 << W); ret++) begin
      rst_n = 1'b0;
      ctl_out = W'(~ret);
      ready = 1'b1;
      hitless = 1'b0;
      retained = W'(ret + 5);
      @(posedge clk);
      @(negedge clk);
      retained = W'(ret);
      @(posedge clk);
      @(negedge clk);
      exp_pad = W'(ret);
      exp_hold = 1'b0;
      chk_pad("R1 R7");
      chk_hold("R1");
      rst_n = 1'b1;
      prev_ready = 1'b0;
      // live reload: first edges hold the retained pattern
      step(1'b1, 1'b0, W'(~ret), W'(ret + 3));
      step(1'b1, 1'b0, W'(ret * 5 + 1), W'(ret + 9));
      for (int k = 0; k < 48; k++) begin
        logic h, r;
        h = (k < 8) ? 1'b0 : 1'b1;
        r = k[1] ^ k[3] ^ (k[0] & k[2]);
        step(h, r, W'(k * 7 + ret * 3), W'(k + ret));
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule